// File: doc/BRIEF.md
# Register-window packet receive buffer

This block sits on the device side of a slow, asynchronous 8-bit parallel bus. It accepts whole packets as a stream of 32-bit words from a receive path and keeps them in an internal queue. To the bus master it looks like a file of 256 byte-wide registers. The lowest 64 addresses are a window onto one 64-byte page of the packet at the head of the queue. The addresses above the window hold a small set of control and status registers.

The master moves the window by writing a page number, or drops the head packet by writing the pop register. Either write starts a copy engine. The engine refills the window with sixteen aligned 32-bit words, one per clock, in a fixed sequence of known length. The block raises a wait line for as long as that copy runs. Any access that arrives while a copy is in progress is held on wait until the copy has finished, so the master never reads a half-updated window.

When a packet lands in an empty queue, the window is loaded with its first page without any request from the master. The bus strobe passes through a two-flop synchronizer. An access therefore takes effect on the third clock edge after the strobe rises. At that point either the read data is on the bus or wait is high.

Top module: `rwb_window_buffer`

## Requirements
- R1: After reset the packet count, page, status and every window byte read as 0, and bus_wait is low.
- R2: A packet is a run of rx_valid words ending with rx_last. Packets are queued in arrival order, and register 0x42 reads the head packet's length in words. A packet longer than 64 words keeps its first 64 words, and its length reads 64.
- R3: A read of address a below 64 returns byte (a mod 4) of word page*16 + a/4 of the head packet. Byte 0 is bits 7:0 of the word.
- R4: Writing register 0x41 sets the page, and 0x41 reads back the current page. The write starts a refill that copies sixteen words, one per clock, and always lasts exactly sixteen cycles.
- R5: By the third clock edge after bus_strobe rises, either the read data is on bus_rdata or bus_wait is high. bus_wait stays high until the refill that the access waits on, or that it started, is complete.
- R6: A read that arrives during a refill is stalled with bus_wait and then returns the refilled data.
- R7: Window words at or beyond the head packet's length, and all window words while the queue is empty, read as 0. Register 0x42 reads 0 when the queue is empty.
- R8: Any write to register 0x44 removes the head packet, sets the page to 0 and refills the window from the next packet.
- R9: A write to 0x44 on an empty queue changes no state other than status bit 0 of register 0x43. That bit is set and stays set until reset.
- R10: A packet that arrives in an empty queue loads its page 0 into the window automatically.
- R11: A packet that starts while the queue already holds 4 packets is discarded whole and never becomes visible.
- R12: Register 0x40 reads the number of queued packets. Addresses from 0x45 to 0xFF read 0. Writes to any address other than 0x41 and 0x44 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A packet word is present on rx_word |
| rx_word | input | 32 | Packet word from the receive path |
| rx_last | input | 1 | The current word is the last of its packet |
| bus_strobe | input | 1 | Asynchronous access strobe, active high |
| bus_we | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 8 | Register address, stable while the strobe is high |
| bus_wdata | input | 8 | Write data, stable while the strobe is high |
| bus_rdata | output | 8 | Read data for the last completed read |
| bus_wait | output | 1 | Access not finished; the master holds the strobe |

## Verification
The window is read at several pages of one packet: the first page, a page that runs past the end of the packet, and a page wholly beyond it. These reads separate the correct word arithmetic from off-by-one errors at the length boundary, and the test data is chosen so that the byte order and the word index are both visible. The queue is exercised with packets of different lengths. One packet arrives into an empty queue, one arrives while the queue is full, and one is longer than the storage slot. Popping through them shows that the order, truncation and discard rules are kept apart. Pops on an empty queue, reads that collide with an automatic refill, and accesses to unmapped or read-only registers cover the stall and the cases that must have no effect.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 8;

    localparam logic [BUS_AW-1:0] RA_COUNT = 8'h40;
    localparam logic [BUS_AW-1:0] RA_PAGE  = 8'h41;
    localparam logic [BUS_AW-1:0] RA_LEN   = 8'h42;
    localparam logic [BUS_AW-1:0] RA_STAT  = 8'h43;
    localparam logic [BUS_AW-1:0] RA_POP   = 8'h44;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } bus_st_e;

endpackage

// File: rtl/rwb_sync.sv
module rwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rwb_pkt_queue.sv
module rwb_pkt_queue #(
    parameter  int NUM_PKT   = 4,
    parameter  int MAX_WORDS = 64,
    parameter  int DATA_W    = 32,
    localparam int WIDX_W    = $clog2(MAX_WORDS),
    localparam int LEN_W     = $clog2(MAX_WORDS + 1),
    localparam int CNT_W     = $clog2(NUM_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_last,
    input  logic              pop,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic [LEN_W-1:0]  head_len,
    output logic [CNT_W-1:0]  count,
    output logic              q_empty,
    output logic              commit_empty
);
    localparam int PTR_W  = (NUM_PKT > 1) ? $clog2(NUM_PKT) : 1;
    localparam int MEM_D  = NUM_PKT * MAX_WORDS;
    localparam int MEM_AW = $clog2(MEM_D);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
        logic [LEN_W-1:0] wcnt;
        logic             in_pkt;
        logic             drop;
    } q_t;

    q_t q_d, q_q;
    logic [DATA_W-1:0] mem   [MEM_D];
    logic [LEN_W-1:0]  len_q [NUM_PKT];

    logic              drop_now, store, commit, pop_ok;
    logic [LEN_W-1:0]  commit_len;
    logic [MEM_AW-1:0] waddr, raddr;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_PKT - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d        = q_q;
        store      = 1'b0;
        commit     = 1'b0;
        drop_now   = q_q.in_pkt ? q_q.drop : (q_q.count == CNT_W'(NUM_PKT));
        commit_len = q_q.wcnt;
        if (rx_valid) begin
            store      = !drop_now && (q_q.wcnt < LEN_W'(MAX_WORDS));
            commit_len = q_q.wcnt + LEN_W'(store);
            q_d.in_pkt = !rx_last;
            q_d.drop   = drop_now;
            q_d.wcnt   = commit_len;
            if (rx_last) begin
                q_d.wcnt = '0;
                commit   = !drop_now;
                if (commit) q_d.tail = ptr_next(q_q.tail);
            end
        end
        pop_ok = pop && (q_q.count != '0);
        if (pop_ok) q_d.head = ptr_next(q_q.head);
        q_d.count = q_q.count + CNT_W'(commit) - CNT_W'(pop_ok);
    end

    assign waddr = MEM_AW'(q_q.tail) * MEM_AW'(MAX_WORDS) + MEM_AW'(q_q.wcnt);
    assign raddr = MEM_AW'(q_q.head) * MEM_AW'(MAX_WORDS) + MEM_AW'(rd_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (store)  mem[waddr]     <= rx_word;
        if (commit) len_q[q_q.tail] <= commit_len;
    end

    assign rd_word      = mem[raddr];
    assign q_empty      = (q_q.count == '0);
    assign head_len     = q_empty ? '0 : len_q[q_q.head];
    assign count        = q_q.count;
    assign commit_empty = commit && q_empty;

    // R11
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.count <= CNT_W'(NUM_PKT));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && q_empty) |=> $stable(q_q.head));
endmodule

// File: rtl/rwb_copy_engine.sv
module rwb_copy_engine #(
    parameter  int WPP    = 16,
    parameter  int PAGE_W = 8,
    parameter  int LEN_W  = 7,
    parameter  int WIDX_W = 6,
    parameter  int DATA_W = 32,
    localparam int CNT_W  = $clog2(WPP)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [PAGE_W-1:0]            start_page,
    input  logic [LEN_W-1:0]             head_len,
    input  logic                         q_empty,
    input  logic [DATA_W-1:0]            rd_word,
    output logic [WIDX_W-1:0]            rd_idx,
    output logic                         busy,
    output logic [WPP-1:0][DATA_W-1:0]   window
);
    localparam int FULL_W = PAGE_W + CNT_W;

    typedef struct packed {
        logic                       busy;
        logic [CNT_W-1:0]           cnt;
        logic [PAGE_W-1:0]          page;
        logic [WPP-1:0][DATA_W-1:0] win;
    } e_t;

    e_t e_d, e_q;
    logic [FULL_W-1:0] full_idx;
    logic              word_ok;

    assign full_idx = {e_q.page, e_q.cnt};
    assign word_ok  = !q_empty && (full_idx < FULL_W'(head_len));

    always_comb begin
        e_d = e_q;
        if (e_q.busy) begin
            e_d.win[e_q.cnt] = word_ok ? rd_word : '0;
            e_d.cnt          = e_q.cnt + 1'b1;
            if (e_q.cnt == CNT_W'(WPP - 1)) e_d.busy = 1'b0;
        end else if (start) begin
            e_d.busy = 1'b1;
            e_d.cnt  = '0;
            e_d.page = start_page;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign rd_idx = full_idx[WIDX_W-1:0];
    assign busy   = e_q.busy;
    assign window = e_q.win;

    // R4
    fixed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.busy && e_q.cnt == CNT_W'(WPP - 1)) |=> !e_q.busy);

    // R7
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.busy && !word_ok && e_q.cnt == '0) |=> (e_q.win[0] == '0));
endmodule

// File: rtl/rwb_window_buffer.sv
module rwb_window_buffer
    import rwb_pkg::*;
#(
    parameter int NUM_PKT     = 4,
    parameter int MAX_WORDS   = 64,
    parameter int PAGE_BYTES  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [31:0] rx_word,
    input  logic        rx_last,
    input  logic        bus_strobe,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_wait
);
    localparam int DATA_W = 32;
    localparam int WPP    = PAGE_BYTES / (DATA_W / 8);
    localparam int BSEL_W = $clog2(PAGE_BYTES);
    localparam int WIDX_W = $clog2(MAX_WORDS);
    localparam int LEN_W  = $clog2(MAX_WORDS + 1);
    localparam int CNT_W  = $clog2(NUM_PKT + 1);

    typedef struct packed {
        bus_st_e           state;
        logic              s_prev;
        logic              wait_o;
        logic              done;
        logic              pend;
        logic              under;
        logic [BUS_DW-1:0] page;
        logic [BUS_DW-1:0] rdata;
        logic [BUS_AW-1:0] addr;
        logic              we;
        logic [BUS_DW-1:0] wdata;
    } t_t;

    t_t st_d, st_q;

    logic                       strobe_s, rise, free, do_acc, started;
    logic                       q_pop, q_empty, q_commit_empty, eng_start, eng_busy;
    logic [BUS_DW-1:0]          eng_page, rd_val, acc_wdata;
    logic [BUS_AW-1:0]          acc_addr;
    logic                       acc_we;
    logic [DATA_W-1:0]          q_rd_word;
    logic [WIDX_W-1:0]          q_rd_idx;
    logic [LEN_W-1:0]           q_head_len;
    logic [CNT_W-1:0]           q_count;
    logic [WPP-1:0][DATA_W-1:0] win;

    rwb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_strobe), .dout(strobe_s)
    );

    rwb_pkt_queue #(.NUM_PKT(NUM_PKT), .MAX_WORDS(MAX_WORDS), .DATA_W(DATA_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
        .rx_last(rx_last), .pop(q_pop), .rd_idx(q_rd_idx), .rd_word(q_rd_word),
        .head_len(q_head_len), .count(q_count), .q_empty(q_empty),
        .commit_empty(q_commit_empty)
    );

    rwb_copy_engine #(.WPP(WPP), .PAGE_W(BUS_DW), .LEN_W(LEN_W),
                      .WIDX_W(WIDX_W), .DATA_W(DATA_W)) u_copy (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .start_page(eng_page),
        .head_len(q_head_len), .q_empty(q_empty), .rd_word(q_rd_word),
        .rd_idx(q_rd_idx), .busy(eng_busy), .window(win)
    );

    assign acc_addr  = (st_q.state == ST_IDLE) ? bus_addr  : st_q.addr;
    assign acc_we    = (st_q.state == ST_IDLE) ? bus_we    : st_q.we;
    assign acc_wdata = (st_q.state == ST_IDLE) ? bus_wdata : st_q.wdata;

    always_comb begin
        rd_val = '0;
        if (acc_addr < BUS_AW'(PAGE_BYTES)) begin
            rd_val = win[acc_addr[BSEL_W-1:2]][{acc_addr[1:0], 3'b000} +: 8];
        end else begin
            case (acc_addr)
                RA_COUNT: rd_val = BUS_DW'(q_count);
                RA_PAGE:  rd_val = st_q.page;
                RA_LEN:   rd_val = BUS_DW'(q_head_len);
                RA_STAT:  rd_val = {{(BUS_DW-1){1'b0}}, st_q.under};
                default:  rd_val = '0;
            endcase
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.s_prev = strobe_s;
        rise        = strobe_s && !st_q.s_prev;
        free        = !eng_busy && !st_q.pend;
        q_pop       = 1'b0;
        eng_start   = 1'b0;
        eng_page    = '0;
        do_acc      = 1'b0;
        started     = 1'b0;

        if (st_q.state == ST_IDLE) begin
            if (rise) begin
                st_d.addr  = bus_addr;
                st_d.we    = bus_we;
                st_d.wdata = bus_wdata;
                if (free) begin
                    do_acc = 1'b1;
                end else begin
                    st_d.state  = ST_BUSY;
                    st_d.wait_o = 1'b1;
                    st_d.done   = 1'b0;
                end
            end
        end else if (free) begin
            if (!st_q.done) begin
                do_acc = 1'b1;
            end else begin
                st_d.state  = ST_IDLE;
                st_d.wait_o = 1'b0;
            end
        end

        if (do_acc) begin
            if (!acc_we) begin
                st_d.rdata = rd_val;
            end else if (acc_addr == RA_PAGE) begin
                st_d.page = acc_wdata;
                eng_page  = acc_wdata;
                started   = 1'b1;
            end else if (acc_addr == RA_POP) begin
                if (!q_empty) begin
                    q_pop     = 1'b1;
                    st_d.page = '0;
                    started   = 1'b1;
                end else begin
                    st_d.under = 1'b1;
                end
            end
            eng_start   = started;
            st_d.state  = started ? ST_BUSY : ST_IDLE;
            st_d.wait_o = started;
            st_d.done   = 1'b1;
        end

        if (st_q.pend && !eng_busy) begin
            eng_start = 1'b1;
            eng_page  = '0;
            st_d.page = '0;
            st_d.pend = 1'b0;
        end
        if (q_commit_empty) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign bus_wait  = st_q.wait_o;

    // R5
    wait_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE && rise && !free) |=> bus_wait);

    // R6
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wait) |-> !eng_busy);

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.under |=> st_q.under);
endmodule

// File: tb/test_rwb_window_buffer.sv
module test_rwb_window_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        rx_last = 1'b0;
    logic        bus_strobe = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_wait;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit fin   = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_data  = '0;

    always #2 clk = ~clk;

    rwb_window_buffer i_rwb_window_buffer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
        .rx_last(rx_last), .bus_strobe(bus_strobe), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait)
    );

    function automatic logic [31:0] pw(input logic [7:0] s, input int i);
        return {s, 8'(i), ~s, 8'(i) ^ 8'h5A};
    endfunction

    function automatic logic [7:0] win_byte(input logic [7:0] s, input int len,
                                            input int page, input int a);
        int w;
        logic [31:0] v;
        w = page * 16 + a / 4;
        if (w >= len) return 8'h00;
        v = pw(s, w);
        return v[8*(a%4) +: 8];
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !fin) begin
            fin = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
            summary();
            $finish;
        end
    end

    // scoreboard monitor
    always @(posedge clk) begin
        if (rsp_valid) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rsp_data !== e) begin
                n_err++;
                $display("FAIL %s: actual %02h expected %02h", t, rsp_data, e);
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
        n_chk++;
        if (act !== e) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", t, act, e);
        end
    endtask

    task automatic xfer(input logic we, input logic [7:0] a, input logic [7:0] wd,
                        output logic [7:0] rd, output logic sw);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; bus_strobe = 1'b1;
        repeat (4) @(negedge clk);
        sw = bus_wait;
        while (bus_wait) @(negedge clk);
        rd = bus_rdata;
        bus_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string t,
                          output logic sw);
        logic [7:0] d;
        exp_q.push_back(e);
        tag_q.push_back(t);
        xfer(1'b0, a, 8'h00, d, sw);
        rsp_data  = d;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        logic sw;
        rd_exp(a, e, t, sw);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, output logic sw);
        logic [7:0] x;
        xfer(1'b1, a, d, x, sw);
    endtask

    task automatic send_pkt(input logic [7:0] s, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_word = pw(s, i); rx_last = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic chk_page(input logic [7:0] s, input int len, input int page,
                            input string t);
        rd(8'd0,  win_byte(s, len, page, 0),  t);
        rd(8'd5,  win_byte(s, len, page, 5),  t);
        rd(8'd18, win_byte(s, len, page, 18), t);
        rd(8'd63, win_byte(s, len, page, 63), t);
    endtask

    initial begin
        logic sw;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 wait after reset", {31'd0, bus_wait}, 32'd0);
        rd(8'h40, 8'h00, "R1 count");
        rd(8'h41, 8'h00, "R1 page");
        rd(8'h43, 8'h00, "R1 status");
        rd(8'h00, 8'h00, "R1 window byte 0");

        // R10 / R3 first packet auto loads page 0
        send_pkt(8'h11, 20);
        rd(8'h40, 8'h01, "R12 count one");
        rd(8'h42, 8'd20, "R2 head length");
        chk_page(8'h11, 20, 0, "R10 R3 auto page0");

        // R4 page select, R7 tail zeros
        wr(8'h41, 8'h01, sw);
        chk("R4 R5 wait during refill", {31'd0, sw}, 32'd1);
        rd(8'h41, 8'h01, "R4 page readback");
        chk_page(8'h11, 20, 1, "R7 R3 page1 partial");
        wr(8'h41, 8'h05, sw);
        chk_page(8'h11, 20, 5, "R7 page beyond length");

        // R2 order, no refill on non-empty arrival
        send_pkt(8'h22, 8);
        rd(8'h40, 8'h02, "R12 count two");
        rd(8'h42, 8'd20, "R2 head unchanged");
        rd(8'h41, 8'h05, "R4 page kept");
        rd(8'h00, 8'h00, "R10 no refill when non-empty");
        wr(8'h41, 8'h00, sw);
        chk_page(8'h11, 20, 0, "R4 back to page0");

        // R8 pop
        wr(8'h44, 8'h00, sw);
        chk("R8 wait during pop refill", {31'd0, sw}, 32'd1);
        rd(8'h40, 8'h01, "R8 count after pop");
        rd(8'h42, 8'd8,  "R8 next length");
        rd(8'h41, 8'h00, "R8 page reset");
        chk_page(8'h22, 8, 0, "R8 next packet window");
        wr(8'h44, 8'h00, sw);
        rd(8'h40, 8'h00, "R8 empty count");
        rd(8'h42, 8'h00, "R7 empty length");
        rd(8'h00, 8'h00, "R7 empty window");
        rd(8'h43, 8'h00, "R9 no underflow yet");

        // R9 underflow
        wr(8'h44, 8'h00, sw);
        chk("R9 empty pop no wait", {31'd0, sw}, 32'd0);
        rd(8'h43, 8'h01, "R9 underflow set");
        rd(8'h40, 8'h00, "R9 count unchanged");
        wr(8'h44, 8'h00, sw);
        rd(8'h43, 8'h01, "R9 underflow sticky");

        // R6 read collides with auto refill
        send_pkt(8'h33, 16);
        rd_exp(8'd4, win_byte(8'h33, 16, 0, 4), "R6 stalled read data", sw);
        chk("R6 stalled read saw wait", {31'd0, sw}, 32'd1);

        // R11 full queue drops, R2 truncation
        send_pkt(8'h44, 3);
        send_pkt(8'h55, 70);
        send_pkt(8'h66, 5);
        rd(8'h40, 8'h04, "R11 full count");
        send_pkt(8'h77, 6);
        rd(8'h40, 8'h04, "R11 drop keeps count");
        rd(8'h42, 8'd16, "R2 head still oldest");
        wr(8'h44, 8'h00, sw);
        rd(8'h42, 8'd3, "R2 order second");
        chk_page(8'h44, 3, 0, "R7 short packet window");
        wr(8'h44, 8'h00, sw);
        rd(8'h42, 8'd64, "R2 truncated length");
        wr(8'h41, 8'h03, sw);
        rd(8'd63, win_byte(8'h55, 64, 3, 63), "R2 last kept word");
        rd(8'd0,  win_byte(8'h55, 64, 3, 0),  "R3 page3 first word");
        wr(8'h41, 8'h04, sw);
        rd(8'd0, 8'h00, "R2 words past 64 dropped");
        wr(8'h44, 8'h00, sw);
        rd(8'h42, 8'd5, "R11 last kept packet");
        chk_page(8'h66, 5, 0, "R11 window of last kept");
        wr(8'h44, 8'h00, sw);
        rd(8'h40, 8'h00, "R11 dropped packet absent");

        // R12 unmapped and read-only
        rd(8'h80, 8'h00, "R12 unmapped read");
        rd(8'hFF, 8'h00, "R12 top address read");
        wr(8'h40, 8'h09, sw);
        rd(8'h40, 8'h00, "R12 count write ignored");
        wr(8'h43, 8'h00, sw);
        rd(8'h43, 8'h01, "R12 status write ignored");
        wr(8'h10, 8'hAA, sw);
        rd(8'h10, 8'h00, "R12 window write ignored");

        repeat (4) @(negedge clk);
        fin = 1'b1;
        summary();
        $finish;
    end
endmodule